// File: doc/BRIEF.md
# Double-to-Single Rounding Unit

This unit takes one binary64 operand and narrows it to the precision and range of binary32. The rounded value is then widened back, exactly, into binary64 form. A floating-point pipeline uses it before a value is stored as single precision, so that the register copy and the stored copy agree.

A 2-bit control selects the rounding direction. A separate control selects a non-IEEE mode that flushes tiny results to zero. Each operation produces:

- the widened result;
- a class code for the single-precision result;
- per-operation pulses for overflow, underflow, inexact and signalling-NaN invalid, plus a summary bit;
- a 4-bit condition field for record-form use. A record-enable input gates this field, and a trap mask forms its enabled-exception bit.

All outputs are registered. Results appear one clock after the operand is presented, and a new operand may be presented every cycle.

Top module: `dbl2sgl_round`

## Requirements
- R1: All outputs are registered. The outputs for an operand appear after the first rising clock edge that samples it. A synchronous active-low reset clears every output to zero.
- R2: With mode 00, a finite input is rounded to 24 significant bits, ties to even. The result is written as the exactly equal binary64 value (a binary32 subnormal becomes a normal binary64).
- R3: The rounding control is encoded as 00 nearest-even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity. Each mode gives the correctly directed binary32 value.
- R4: When the rounded magnitude exceeds the largest binary32 finite value, overflow, inexact and summary are raised. The result is a signed infinity in mode 00, and in the mode that rounds away from zero for that sign. In the other modes it is the largest finite binary32 magnitude with the input sign.
- R5: With flush mode off, an input whose exponent is below the binary32 normal range rounds to a binary32 subnormal, zero or the smallest normal. Underflow is raised only when that input is also inexact (tininess is judged before rounding).
- R6: With flush mode on, any nonzero input below the binary32 normal range gives a zero of the input sign and raises underflow, inexact and summary.
- R7: A quiet NaN input (exponent all ones, fraction bit 51 set) keeps its sign and fraction bits 51..29. Fraction bits 28..0 are cleared, and no flag is raised.
- R8: A signalling NaN input (exponent all ones, bit 51 clear, nonzero fraction) raises invalid and summary. The output has bit 51 set, and keeps the sign and fraction bits 50..29 with bits 28..0 cleared.
- R9: Inexact and summary are raised exactly when a finite input differs from its rounded value. An input already representable in binary32 passes through with no flag.
- R10: Signed zeros and signed infinities pass through unchanged and raise no flag.
- R11: With record enable at 1, the condition field is {summary, enabled summary, invalid, overflow}, from bit 3 down to bit 0. Enabled summary is the OR of the flags masked by trap mask bits [3]=invalid, [2]=overflow, [1]=underflow, [0]=inexact. With record enable at 0 the field is 0000.
- R12: The class output describes the binary32 result: 10001 quiet NaN, 01001 minus infinity, 01000 minus normal, 11000 minus subnormal, 10010 minus zero, 00010 plus zero, 10100 plus subnormal, 00100 plus normal, 00101 plus infinity.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_in | input | 64 | binary64 operand |
| rmode | input | 2 | Rounding direction |
| ftz_en | input | 1 | Flush tiny results to zero |
| rec_en | input | 1 | Record form: enables the condition field |
| trap_mask | input | 4 | Exception enables (invalid, overflow, underflow, inexact) |
| res_out | output | 64 | Rounded value widened to binary64 |
| cls_out | output | 5 | Class code of the binary32 result |
| ox_out | output | 1 | Overflow pulse |
| ux_out | output | 1 | Underflow pulse |
| xx_out | output | 1 | Inexact pulse |
| vxsnan_out | output | 1 | Invalid pulse for a signalling NaN |
| fx_out | output | 1 | Summary of all four flags |
| cond_out | output | 4 | Record-form condition field |

## Verification
Every output, including the condition field, is due exactly one rising edge after the operand is sampled. Nothing is carried from one operation to the next. The bench changes all inputs on a falling edge, lets one rising edge pass, and compares at the next falling edge. A new operand is driven in that same falling edge, so each comparison sees only the result of the operand before it. The assertions use a single `$past` step for the same reason, and they are gated on the previous cycle being out of reset.

// File: rtl/dsr_pkg.sv
// Shared formats, rounding-mode encoding, flag bundle and class codes
// for the double-to-single rounding unit.
package dsr_pkg;

    localparam int DW      = 64;            // binary64 width
    localparam int DEXP    = 11;            // binary64 exponent width
    localparam int DFRAC   = 52;            // binary64 fraction width
    localparam int SW      = 32;            // binary32 width
    localparam int SEXP    = 8;             // binary32 exponent width
    localparam int SFRAC   = 23;            // binary32 fraction width
    localparam int DBIAS   = 1023;
    localparam int SBIAS   = 127;
    localparam int DROP    = DFRAC - SFRAC; // bits dropped for a normal result
    localparam int SMIN_E  = 1 - SBIAS;     // smallest normal unbiased exponent
    localparam int SMAX_E  = SBIAS;         // largest normal unbiased exponent
    localparam int SH_CAP  = SFRAC + 2;     // extra right shift beyond DROP that empties the significand
    localparam int SHW     = $clog2(SH_CAP + 1);
    localparam int EW      = DEXP + 2;      // signed unbiased exponent width
    localparam int REBIAS  = DBIAS - SBIAS;
    localparam int QBIT    = DFRAC - 1;     // quiet bit of a binary64 NaN

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef struct packed {
        logic ox;   // overflow
        logic ux;   // underflow
        logic xx;   // inexact
        logic vx;   // invalid from signalling NaN
    } flags_t;

    localparam logic [4:0] CLS_QNAN = 5'b10001;
    localparam logic [4:0] CLS_NINF = 5'b01001;
    localparam logic [4:0] CLS_NNRM = 5'b01000;
    localparam logic [4:0] CLS_NSUB = 5'b11000;
    localparam logic [4:0] CLS_NZER = 5'b10010;
    localparam logic [4:0] CLS_PZER = 5'b00010;
    localparam logic [4:0] CLS_PSUB = 5'b10100;
    localparam logic [4:0] CLS_PNRM = 5'b00100;
    localparam logic [4:0] CLS_PINF = 5'b00101;

endpackage

// File: rtl/dsr_narrow.sv
// Narrows a binary64 operand to a binary32 encoding under the selected
// rounding direction and flush mode, and raises the exception flags.
// Assumes: purely combinational; NaN payloads are truncated and
// signalling NaNs are quietened; tininess is detected before rounding.
module dsr_narrow
    import dsr_pkg::*;
(
    input  logic [DW-1:0] op_i,
    input  logic [1:0]    rmode_i,
    input  logic          ftz_i,
    output logic [SW-1:0] sp_o,
    output flags_t        flg_o
);

    localparam int VW = DFRAC + 1 + SH_CAP;
    localparam logic [SW-2:0] SP_INF_MAG = {{SEXP{1'b1}}, {SFRAC{1'b0}}};
    localparam logic [SW-2:0] SP_MAX_MAG = {{(SEXP-1){1'b1}}, 1'b0, {SFRAC{1'b1}}};

    logic                 sgn;
    logic [DEXP-1:0]      dexp;
    logic [DFRAC-1:0]     dfr;
    logic                 exp_all1, is_nan, is_inf, is_zero;
    logic signed [EW-1:0] unb;
    logic                 tiny, huge;
    logic [DFRAC:0]       sig;
    logic [SHW-1:0]       sh2;
    logic [VW-1:0]        vsh;
    logic [SFRAC:0]       kept;
    logic                 guard, sticky, lossy, inc, away;
    logic [SEXP-1:0]      exp_base;
    logic [SW-2:0]        base_mag, rnd_mag;
    logic                 ovf;

    assign {sgn, dexp, dfr} = op_i;
    assign exp_all1 = &dexp;
    assign is_nan   = exp_all1 & (|dfr);
    assign is_inf   = exp_all1 & ~(|dfr);
    assign is_zero  = (dexp == '0) & ~(|dfr);

    // unbiased exponent; binary64 subnormals take the minimum exponent
    assign unb  = (dexp == '0) ? EW'(1 - DBIAS)
                               : $signed({{(EW-DEXP){1'b0}}, dexp}) - EW'(DBIAS);
    assign tiny = unb < EW'(SMIN_E);
    assign huge = unb > EW'(SMAX_E);
    assign sig  = {dexp != '0, dfr};

    // extra denormalising shift for results below the binary32 normal range
    always_comb begin
        if (!tiny)
            sh2 = '0;
        else if ((EW'(SMIN_E) - unb) > EW'(SH_CAP))
            sh2 = SHW'(SH_CAP);
        else
            sh2 = SHW'(EW'(SMIN_E) - unb);
    end

    // align: kept significand, guard bit and sticky remainder
    assign vsh    = {sig, {SH_CAP{1'b0}}} >> sh2;
    assign kept   = vsh[VW-1 -: SFRAC+1];
    assign guard  = vsh[VW-SFRAC-2];
    assign sticky = |vsh[VW-SFRAC-3:0];
    assign lossy  = guard | sticky;

    // round-up decision per direction
    always_comb begin
        case (rmode_i)
            RM_NEAR: inc = guard & (sticky | kept[0]);
            RM_ZERO: inc = 1'b0;
            RM_PINF: inc = lossy & ~sgn;
            RM_NINF: inc = lossy & sgn;
            default: inc = 1'b0;
        endcase
    end

    // whether overflow goes to infinity or saturates at the largest finite value
    always_comb begin
        case (rmode_i)
            RM_NEAR: away = 1'b1;
            RM_PINF: away = ~sgn;
            RM_NINF: away = sgn;
            default: away = 1'b0;
        endcase
    end

    // hidden bit of kept carries into the exponent field (one below true value)
    assign exp_base = tiny ? '0 : SEXP'(unb + EW'(SBIAS - 1));
    assign base_mag = {exp_base, {SFRAC{1'b0}}} + (SW-1)'(kept);
    assign rnd_mag  = base_mag + (SW-1)'(inc);
    assign ovf      = huge | (rnd_mag == SP_INF_MAG);

    // select the binary32 encoding and flags by operand category
    always_comb begin
        flg_o = '0;
        if (is_nan) begin
            sp_o     = {sgn, {SEXP{1'b1}}, 1'b1, dfr[QBIT-1 -: SFRAC-1]};
            flg_o.vx = ~dfr[QBIT];
        end else if (is_inf) begin
            sp_o = {sgn, SP_INF_MAG};
        end else if (is_zero) begin
            sp_o = {sgn, {(SW-1){1'b0}}};
        end else if (tiny && ftz_i) begin
            sp_o     = {sgn, {(SW-1){1'b0}}};
            flg_o.ux = 1'b1;
            flg_o.xx = 1'b1;
        end else if (ovf) begin
            sp_o     = {sgn, away ? SP_INF_MAG : SP_MAX_MAG};
            flg_o.ox = 1'b1;
            flg_o.xx = 1'b1;
        end else begin
            sp_o     = {sgn, rnd_mag};
            flg_o.xx = lossy;
            flg_o.ux = tiny & lossy;
        end
    end

endmodule

// File: rtl/dsr_widen.sv
// Widens a binary32 encoding exactly into binary64 and classifies it.
// Assumes: combinational; binary32 subnormals become binary64 normals
// after a leading-zero normalisation.
module dsr_widen
    import dsr_pkg::*;
(
    input  logic [SW-1:0] sp_i,
    output logic [DW-1:0] dp_o,
    output logic [4:0]    cls_o
);

    logic              sgn;
    logic [SEXP-1:0]   e8;
    logic [SFRAC-1:0]  man, nman;
    logic [SHW-1:0]    lz;
    logic              hit;

    assign {sgn, e8, man} = sp_i;

    // count leading zeros of the binary32 fraction
    always_comb begin
        lz  = '0;
        hit = 1'b0;
        for (int i = SFRAC - 1; i >= 0; i--) begin
            if (!hit) begin
                if (man[i]) hit = 1'b1;
                else        lz  = lz + 1'b1;
            end
        end
    end

    assign nman = man << (lz + 1'b1);

    // re-encode with the binary64 bias
    always_comb begin
        if (&e8)
            dp_o = {sgn, {DEXP{1'b1}}, man, {DROP{1'b0}}};
        else if (e8 == '0 && man == '0)
            dp_o = {sgn, {(DW-1){1'b0}}};
        else if (e8 == '0)
            dp_o = {sgn, DEXP'(REBIAS) - DEXP'(lz), nman, {DROP{1'b0}}};
        else
            dp_o = {sgn, DEXP'(e8) + DEXP'(REBIAS), man, {DROP{1'b0}}};
    end

    // class code of the binary32 value
    always_comb begin
        if (&e8)
            cls_o = (man != '0) ? CLS_QNAN : (sgn ? CLS_NINF : CLS_PINF);
        else if (e8 == '0 && man == '0)
            cls_o = sgn ? CLS_NZER : CLS_PZER;
        else if (e8 == '0)
            cls_o = sgn ? CLS_NSUB : CLS_PSUB;
        else
            cls_o = sgn ? CLS_NNRM : CLS_PNRM;
    end

endmodule

// File: rtl/dbl2sgl_round.sv
// Double-to-single rounding unit: narrows, widens, registers the result,
// class, flag pulses and record-form condition field with one cycle of latency.
// Assumes: one operand per cycle, no stall; flags describe only the
// operand sampled on the previous edge.
module dbl2sgl_round
    import dsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [63:0]   op_in,
    input  logic [1:0]    rmode,
    input  logic          ftz_en,
    input  logic          rec_en,
    input  logic [3:0]    trap_mask,
    output logic [63:0]   res_out,
    output logic [4:0]    cls_out,
    output logic          ox_out,
    output logic          ux_out,
    output logic          xx_out,
    output logic          vxsnan_out,
    output logic          fx_out,
    output logic [3:0]    cond_out
);

    logic [SW-1:0] sp_w;
    flags_t        flg_w;
    logic [DW-1:0] dp_w;
    logic [4:0]    cls_w;
    logic          fx_w, fex_w;

    dsr_narrow u_narrow (
        .op_i    (op_in),
        .rmode_i (rmode),
        .ftz_i   (ftz_en),
        .sp_o    (sp_w),
        .flg_o   (flg_w)
    );

    dsr_widen u_widen (
        .sp_i  (sp_w),
        .dp_o  (dp_w),
        .cls_o (cls_w)
    );

    assign fx_w  = flg_w.ox | flg_w.ux | flg_w.xx | flg_w.vx;
    assign fex_w = |(trap_mask & {flg_w.vx, flg_w.ox, flg_w.ux, flg_w.xx});

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out    <= '0;
            cls_out    <= '0;
            ox_out     <= 1'b0;
            ux_out     <= 1'b0;
            xx_out     <= 1'b0;
            vxsnan_out <= 1'b0;
            fx_out     <= 1'b0;
            cond_out   <= '0;
        end else begin
            res_out    <= dp_w;
            cls_out    <= cls_w;
            ox_out     <= flg_w.ox;
            ux_out     <= flg_w.ux;
            xx_out     <= flg_w.xx;
            vxsnan_out <= flg_w.vx;
            fx_out     <= fx_w;
            cond_out   <= rec_en ? {fx_w, fex_w, flg_w.vx, flg_w.ox} : 4'b0000;
        end
    end

    AST_REC_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rec_en)) |-> cond_out == 4'b0000); // R11

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_in[62:0]) == 63'd0) |-> (res_out == $past(op_in) && !fx_out)); // R10

    AST_SNAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_in[62:52]) == 11'h7FF && !$past(op_in[51]) && $past(op_in[50:0]) != 51'd0)
        |-> (vxsnan_out && fx_out && res_out[51] && res_out[62:52] == 11'h7FF)); // R8

    AST_RZ_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rmode) == 2'b01 && $past(op_in[62:52]) != 11'h7FF)
        |-> res_out[62:52] != 11'h7FF); // R3

    AST_FTZ_NO_SUBN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ftz_en)) |-> (cls_out != CLS_PSUB && cls_out != CLS_NSUB)); // R6

    AST_UX_TINY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ux_out) |-> $past(op_in[62:52]) < 11'd897); // R5

    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ox_out |-> (xx_out && fx_out && !ux_out)); // R4

endmodule

// File: tb/dbl2sgl_round_tb_top.sv
`timescale 1ns/1ps
module dbl2sgl_round_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_in = '0;
    logic [1:0]  rmode = '0;
    logic        ftz_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [3:0]  trap_mask = '0;
    logic [63:0] res_out;
    logic [4:0]  cls_out;
    logic        ox_out, ux_out, xx_out, vxsnan_out, fx_out;
    logic [3:0]  cond_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    dbl2sgl_round dut_i (
        .clk(clk), .rst_n(rst_n), .op_in(op_in), .rmode(rmode), .ftz_en(ftz_en),
        .rec_en(rec_en), .trap_mask(trap_mask), .res_out(res_out), .cls_out(cls_out),
        .ox_out(ox_out), .ux_out(ux_out), .xx_out(xx_out), .vxsnan_out(vxsnan_out),
        .fx_out(fx_out), .cond_out(cond_out)
    );

    // exact-arithmetic reference: returns {result, ox, ux, xx, vx}
    function automatic logic [67:0] ref_conv(input logic [63:0] x, input logic [1:0] rm, input logic ftz);
        logic s; logic [10:0] e; logic [51:0] f, fr;
        longint m, n, r, half;
        int ex, q, d, cmp, p;
        logic nz, up, tiny;
        logic [63:0] y;
        s = x[63]; e = x[62:52]; f = x[51:0];
        if (e == 11'h7FF) begin
            if (f == 52'd0) return {x, 4'b0000};
            return {s, 11'h7FF, 1'b1, f[50:29], 29'd0, 3'b000, ~f[51]};
        end
        if (e == 11'd0 && f == 52'd0) return {x, 4'b0000};
        m  = (e == 11'd0) ? longint'(f) : ((longint'(1) << 52) | longint'(f));
        ex = (e == 11'd0) ? -1022 : int'(e) - 1023;
        tiny = ex < -126;
        if (tiny && ftz) return {s, 63'd0, 4'b0110};
        q = ((ex < -126) ? -126 : ex) - 23;
        d = q - (ex - 52);
        if (d > 60) begin
            n = 0; cmp = -1; nz = 1'b1;
        end else begin
            n = m >>> d;
            r = m - (n << d);
            half = longint'(1) << (d - 1);
            cmp = (r > half) ? 1 : ((r == half) ? 0 : -1);
            nz = (r != 0);
        end
        case (rm)
            2'd0:    up = (cmp > 0) || (cmp == 0 && n[0]);
            2'd1:    up = 1'b0;
            2'd2:    up = nz && !s;
            default: up = nz && s;
        endcase
        n = n + (up ? 1 : 0);
        if (n == 0) return {s, 63'd0, 1'b0, tiny && nz, nz, 1'b0};
        p = 0;
        for (int i = 0; i < 26; i++) if (n[i]) p = i;
        if (q + p > 127) begin
            if (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd3 && s)) y = {s, 11'h7FF, 52'd0};
            else y = {s, 11'd1150, 23'h7FFFFF, 29'd0};
            return {y, 4'b1010};
        end
        fr = 52'(n << (52 - p));
        y  = {s, 11'(q + p + 1023), fr};
        return {y, 1'b0, tiny && nz, nz, 1'b0};
    endfunction

    function automatic logic [4:0] ref_cls(input logic [63:0] y);
        if (y[62:52] == 11'h7FF) return (y[51:0] != 52'd0) ? 5'b10001 : (y[63] ? 5'b01001 : 5'b00101);
        if (y[62:0] == 63'd0)    return y[63] ? 5'b10010 : 5'b00010;
        if (y[62:52] < 11'd897)  return y[63] ? 5'b11000 : 5'b10100;
        return y[63] ? 5'b01000 : 5'b00100;
    endfunction

    // drive on a falling edge, let one rising edge capture, compare on the next falling edge
    task automatic apply(input logic [63:0] x, input logic [1:0] rm, input logic ftz,
                         input logic rec, input logic [3:0] mk, input string tag);
        logic [67:0] ev; logic [63:0] er; logic [3:0] ef, ec, af; logic efx, efex; logic [4:0] ecl;
        ev  = ref_conv(x, rm, ftz);
        er  = ev[67:4];
        ef  = ev[3:0];
        efx = |ef;
        efex = |(mk & {ef[0], ef[3], ef[2], ef[1]});
        ec  = rec ? {efx, efex, ef[0], ef[3]} : 4'b0000;
        ecl = ref_cls(er);
        @(negedge clk);
        op_in = x; rmode = rm; ftz_en = ftz; rec_en = rec; trap_mask = mk;
        @(posedge clk);
        @(negedge clk);
        af = {ox_out, ux_out, xx_out, vxsnan_out};
        total++;
        if (res_out !== er || af !== ef || fx_out !== efx || cls_out !== ecl || cond_out !== ec) begin
            bad++;
            $display("FAIL %s op=%h rm=%0d ftz=%0d res=%h exp=%h flags=%b exp=%b fx=%b exp=%b cls=%b exp=%b cond=%b exp=%b",
                     tag, x, rm, ftz, res_out, er, af, ef, fx_out, efx, cls_out, ecl, cond_out, ec);
        end
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] x;
        void'($urandom(32'd20240));
        // R1: reset clears every output
        op_in = 64'h7FF0000000000001; rec_en = 1'b1; trap_mask = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if ({res_out, cls_out, ox_out, ux_out, xx_out, vxsnan_out, fx_out, cond_out} !== '0) begin
            bad++;
            $display("FAIL R1 reset outputs res=%h cls=%b cond=%b exp zero", res_out, cls_out, cond_out);
        end
        rst_n = 1'b1;

        apply(64'h3FF0000000000000, 2'd0, 1'b0, 1'b1, 4'hF, "R9 exact one");
        apply(64'h47EFFFFFE0000000, 2'd0, 1'b0, 1'b0, 4'h0, "R9 exact max single");
        apply(64'h3810000000000000, 2'd3, 1'b0, 1'b0, 4'h0, "R9 exact min normal");
        apply(64'h3FB999999999999A, 2'd0, 1'b0, 1'b0, 4'h0, "R2 nearest 0.1");
        for (int i = 0; i < 4; i++) begin
            apply(64'h3FB999999999999A, 2'(i), 1'b0, 1'b0, 4'h0, "R3 modes +0.1");
            apply(64'hBFB999999999999A, 2'(i), 1'b0, 1'b0, 4'h0, "R3 modes -0.1");
            apply(64'h47EFFFFFF0000000, 2'(i), 1'b0, 1'b0, 4'h0, "R4 overflow +");
            apply(64'hC7EFFFFFF0000000, 2'(i), 1'b0, 1'b0, 4'h0, "R4 overflow -");
            apply(64'h7E37E43C8800759C, 2'(i), 1'b0, 1'b1, 4'h0, "R4 huge");
        end
        apply(64'h3800000000000000, 2'd0, 1'b0, 1'b0, 4'h0, "R5 exact subnormal no ux");
        apply(64'h37A0000000000001, 2'd0, 1'b0, 1'b0, 4'h0, "R5 inexact subnormal");
        apply(64'h0000000000000001, 2'd2, 1'b0, 1'b0, 4'h0, "R5 dbl subnormal up");
        apply(64'h0000000000000001, 2'd0, 1'b0, 1'b0, 4'h0, "R5 dbl subnormal near");
        apply(64'h36A0000000000000, 2'd0, 1'b0, 1'b0, 4'h0, "R5 smallest subnormal");
        apply(64'h3690000000000000, 2'd0, 1'b0, 1'b0, 4'h0, "R5 halfway to zero");
        apply(64'h380FFFFFFFFFFFFF, 2'd0, 1'b0, 1'b0, 4'h0, "R5 round to min normal");
        apply(64'h3800000000000000, 2'd0, 1'b1, 1'b1, 4'h2, "R6 flush subnormal");
        apply(64'hB7A0000000000001, 2'd3, 1'b1, 1'b0, 4'h0, "R6 flush negative");
        apply(64'h8000000000000001, 2'd0, 1'b1, 1'b0, 4'h0, "R6 flush dbl subnormal");
        apply(64'h0000000000000000, 2'd0, 1'b1, 1'b1, 4'hF, "R10 plus zero");
        apply(64'h8000000000000000, 2'd2, 1'b0, 1'b1, 4'hF, "R10 minus zero");
        apply(64'h7FF0000000000000, 2'd1, 1'b0, 1'b1, 4'hF, "R10 plus inf");
        apply(64'hFFF0000000000000, 2'd0, 1'b0, 1'b1, 4'hF, "R10 minus inf");
        apply(64'h7FF8000000000123, 2'd0, 1'b0, 1'b1, 4'hF, "R7 qnan truncate");
        apply(64'hFFFC0000F0000000, 2'd1, 1'b0, 1'b0, 4'h0, "R7 qnan payload");
        apply(64'h7FF0000000000001, 2'd0, 1'b0, 1'b0, 4'h0, "R8 snan low payload");
        apply(64'h7FF4000020000000, 2'd0, 1'b0, 1'b1, 4'h8, "R8 snan cond");
        apply(64'h47EFFFFFF0000000, 2'd0, 1'b0, 1'b1, 4'h4, "R11 overflow enabled");
        apply(64'h47EFFFFFF0000000, 2'd0, 1'b0, 1'b1, 4'h0, "R11 overflow masked");
        apply(64'h47EFFFFFF0000000, 2'd0, 1'b0, 1'b0, 4'hF, "R11 record off");
        apply(64'h3FB999999999999A, 2'd0, 1'b0, 1'b1, 4'h1, "R11 inexact enabled");
        apply(64'hC000000000000000, 2'd0, 1'b0, 1'b0, 4'h0, "R12 minus normal");
        apply(64'hB800000000000000, 2'd0, 1'b0, 1'b0, 4'h0, "R12 minus subnormal");

        for (int i = 0; i < 4000; i++) begin
            logic [1:0] rm;
            x = {$urandom, $urandom};
            if ($urandom % 4 != 0) x[62:52] = 11'(860 + ($urandom % 310));
            rm = 2'($urandom);
            apply(x, rm, ($urandom % 8) == 0, 1'($urandom), 4'($urandom),
                  (rm == 2'd0) ? "R2 random" : "R3 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule